// File: doc/BRIEF.md
# Handshaked Command/Response Sequencer

This block is the device-side protocol engine for a byte-serial command link. The host moves one byte at a time through a shift register and marks each byte with an active-low request line. The block answers on an active-low acknowledge line. The first byte of a transaction is a command code. A length lookup, supplied outside the block, says for each direction whether the length is fixed or is carried as the first byte on the wire. After the command byte come an optional count byte and then the argument bytes.

Once all arguments have arrived, the block asks an external dispatcher to run the command. The dispatcher reads the stored arguments through a synchronous read port, writes its reply into a response buffer and reports completion. The block then returns the reply one byte per host request. If the response length is variable, the reply is preceded by a size byte.

Each accepted byte raises a one-cycle interrupt pulse. The argument and response buffers each hold `BUF_DEPTH` bytes and are built so that block RAM can be inferred.

Top module: `hs_cmd_seq`

## Requirements
- R1: After a synchronous reset, `tack_n` is 1, `sr_irq` is 0, `disp_req` is 0, and the sequencer waits for a command byte.
- R2: The block re-evaluates the handshake only when `treq_n` differs from the last level it saw. A new low `treq_n` while `tack_n` is 1 is a byte request, and `tack_n` goes low on that same clock edge. A new high `treq_n` while `tack_n` is 0 releases the acknowledge, and `tack_n` returns to 1. Every other combination leaves `tack_n` unchanged.
- R3: Each accepted byte gives exactly one single-cycle `sr_irq` pulse, coincident with `tack_n` going low. A dropped byte gives none.
- R4: When idle, a request with `sr_dir_h2d`=1 (1 = host to device) latches `sr_in` as the command and applies the lookup. If the argument length is fixed and zero, dispatch starts at once.
- R5: When the lookup marks the argument length as variable (`lk_arg_var`=1), the first byte after the command is taken as the argument count.
- R6: After the last argument byte, `disp_req` rises and stays high until `disp_done`. It presents the command and the argument count, and argument i is readable at `arg_raddr`=i one cycle after the address is applied.
- R7: When the response length is variable, the first byte sent back is the response size: `disp_rsp_size` if `disp_known`=1, otherwise 0. Exactly that many response bytes follow, in buffer order.
- R8: When the response length is fixed at L, exactly L bytes are sent back. Byte i is response-buffer entry i if the command is known and i < `disp_rsp_size`; otherwise it is 0.
- R9: After the last response byte the sequencer is idle again. A fixed zero-length response returns it to idle as soon as `disp_done` arrives.
- R10: A byte whose direction does not match the phase (host-to-device while replying, or device-to-host otherwise) is dropped and the phase is unchanged. `tack_n` still goes low for it.
- R11: Argument bytes beyond `BUF_DEPTH` are not stored and the stored count stops at `BUF_DEPTH`. A declared count above `BUF_DEPTH` therefore never starts a dispatch.
- R12: Changes on `treq_n` while `disp_req` is high are not acted on until the dispatch completes. `tack_n` holds its level throughout the dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| treq_n | input | 1 | Host byte request, active low |
| tack_n | output | 1 | Device acknowledge, active low |
| sr_dir_h2d | input | 1 | Shift direction, 1 = host to device |
| sr_in | input | 8 | Byte shifted in by the host |
| sr_out | output | 8 | Byte presented to the host |
| sr_irq | output | 1 | One-cycle pulse per accepted byte |
| lk_cmd | output | 8 | Command code presented to the length lookup |
| lk_arg_var | input | 1 | Argument length is carried on the wire |
| lk_arg_len | input | 8 | Fixed argument length |
| lk_rsp_var | input | 1 | Response length is carried on the wire |
| lk_rsp_len | input | 8 | Fixed response length |
| disp_req | output | 1 | Dispatch request, held until done |
| disp_cmd | output | 8 | Command to dispatch |
| disp_arg_cnt | output | 8 | Number of stored argument bytes |
| arg_raddr | input | 5 | Argument buffer read address |
| arg_rdata | output | 8 | Argument buffer read data, one cycle latency |
| rsp_we | input | 1 | Response buffer write enable |
| rsp_waddr | input | 5 | Response buffer write address |
| rsp_wdata | input | 8 | Response buffer write data |
| disp_done | input | 1 | Dispatcher finished |
| disp_known | input | 1 | Dispatcher recognised the command |
| disp_rsp_size | input | 8 | Number of response bytes written |

## Verification
The bench sweeps all 256 command codes. The lookup is derived from the code bits, so every mix of fixed and variable lengths appears, including zero-argument commands that dispatch straight from the command byte and zero-length replies that go straight back to idle. A design that stayed in the reply phase would accept the trailing device-to-host probe and pulse the interrupt. A design that skipped zero fill would return stale buffer bytes where a fixed reply outruns the dispatcher's size. A design that treated unknown commands as known would report a non-zero size.

Mismatched-direction bytes are injected both in idle and in the reply phase. A design that acted on them would pulse the interrupt or shift the reply by one byte. The host releases its request during dispatch, and the acknowledge must stay low until completion. An oversized declared count must never start a dispatch.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARGS = 2'd1,
    ST_DISP = 2'd2,
    ST_RESP = 2'd3
  } seq_state_t;
endpackage

// File: rtl/hs_byte_buf.sv
module hs_byte_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hs_handshake.sv
module hs_handshake (
  input  logic clk,
  input  logic rst,
  input  logic treq_n,
  input  logic hold,
  output logic tack_n,
  output logic req_evt
);
  logic treq_seen;
  logic tack_q;
  logic chg;

  // Evaluate the line pair only on a new request level, never while held.
  assign chg     = !hold && (treq_n != treq_seen);
  assign req_evt = chg && !treq_n && tack_q;
  assign tack_n  = tack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      treq_seen <= 1'b1;
      tack_q    <= 1'b1;
    end else if (chg) begin
      treq_seen <= treq_n;
      if (treq_n && !tack_q) tack_q <= 1'b1;   // acknowledge release
      else if (req_evt)      tack_q <= 1'b0;   // byte request
    end
  end

  // R2: acknowledge falls only after a sampled low request outside a hold
  a_r2_tack_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(tack_q) |-> ($past(treq_n) == 1'b0 && $past(hold) == 1'b0));
  // R2: acknowledge rises only after a sampled high request outside a hold
  a_r2_tack_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(tack_q) |-> ($past(treq_n) == 1'b1 && $past(hold) == 1'b0));
endmodule

// File: rtl/hs_cmd_seq.sv
module hs_cmd_seq
  import hs_seq_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int DW        = 8,
  localparam int AW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          treq_n,
  output logic          tack_n,
  input  logic          sr_dir_h2d,
  input  logic [DW-1:0] sr_in,
  output logic [DW-1:0] sr_out,
  output logic          sr_irq,
  output logic [DW-1:0] lk_cmd,
  input  logic          lk_arg_var,
  input  logic [DW-1:0] lk_arg_len,
  input  logic          lk_rsp_var,
  input  logic [DW-1:0] lk_rsp_len,
  output logic          disp_req,
  output logic [DW-1:0] disp_cmd,
  output logic [DW-1:0] disp_arg_cnt,
  input  logic [AW-1:0] arg_raddr,
  output logic [DW-1:0] arg_rdata,
  input  logic          rsp_we,
  input  logic [AW-1:0] rsp_waddr,
  input  logic [DW-1:0] rsp_wdata,
  input  logic          disp_done,
  input  logic          disp_known,
  input  logic [DW-1:0] disp_rsp_size
);
  localparam logic [DW-1:0] DEPTH_C = DW'(BUF_DEPTH);
  localparam logic [DW-1:0] ONE_C   = DW'(1);

  seq_state_t    state;
  logic [DW-1:0] cmd_q, arg_len, rsp_len, arg_pos, rsp_pos, rsp_size, sr_q;
  logic          arg_var, rsp_var, known_q, irq_q;
  logic          req_evt, arg_we;
  logic [DW-1:0] rsp_q;

  hs_handshake u_hs (
    .clk     (clk),
    .rst     (rst),
    .treq_n  (treq_n),
    .hold    (state == ST_DISP),
    .tack_n  (tack_n),
    .req_evt (req_evt)
  );

  assign arg_we = req_evt && (state == ST_ARGS) && sr_dir_h2d &&
                  !arg_var && (arg_pos < DEPTH_C);

  hs_byte_buf #(.DEPTH(BUF_DEPTH), .DW(DW), .AW(AW)) u_arg_buf (
    .clk   (clk),
    .we    (arg_we),
    .waddr (arg_pos[AW-1:0]),
    .wdata (sr_in),
    .raddr (arg_raddr),
    .rdata (arg_rdata)
  );

  hs_byte_buf #(.DEPTH(BUF_DEPTH), .DW(DW), .AW(AW)) u_rsp_buf (
    .clk   (clk),
    .we    (rsp_we),
    .waddr (rsp_waddr),
    .wdata (rsp_wdata),
    .raddr (rsp_pos[AW-1:0]),
    .rdata (rsp_q)
  );

  assign lk_cmd       = sr_in;
  assign sr_out       = sr_q;
  assign sr_irq       = irq_q;
  assign disp_req     = (state == ST_DISP);
  assign disp_cmd     = cmd_q;
  assign disp_arg_cnt = arg_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd_q    <= '0;
      arg_len  <= '0;
      rsp_len  <= '0;
      arg_pos  <= '0;
      rsp_pos  <= '0;
      rsp_size <= '0;
      sr_q     <= '0;
      arg_var  <= 1'b0;
      rsp_var  <= 1'b0;
      known_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_evt && sr_dir_h2d) begin
          irq_q   <= 1'b1;
          cmd_q   <= sr_in;
          arg_var <= lk_arg_var;
          arg_len <= lk_arg_len;
          rsp_var <= lk_rsp_var;
          rsp_len <= lk_rsp_len;
          arg_pos <= '0;
          rsp_pos <= '0;
          state   <= (!lk_arg_var && lk_arg_len == '0) ? ST_DISP : ST_ARGS;
        end
        ST_ARGS: if (req_evt && sr_dir_h2d) begin
          irq_q <= 1'b1;
          if (arg_var) begin
            arg_var <= 1'b0;
            arg_len <= sr_in;
            if (sr_in == arg_pos) state <= ST_DISP;
          end else if (arg_pos < DEPTH_C) begin
            arg_pos <= arg_pos + ONE_C;
            if (arg_pos + ONE_C == arg_len) state <= ST_DISP;
          end
        end
        ST_DISP: if (disp_done) begin
          known_q  <= disp_known;
          rsp_size <= disp_known ? disp_rsp_size : (rsp_var ? '0 : rsp_len);
          state    <= (!rsp_var && rsp_len == '0) ? ST_IDLE : ST_RESP;
        end
        ST_RESP: if (req_evt && !sr_dir_h2d) begin
          irq_q <= 1'b1;
          if (rsp_var) begin
            rsp_var <= 1'b0;
            rsp_len <= rsp_size;
            sr_q    <= rsp_size;
            if (rsp_size == rsp_pos) state <= ST_IDLE;
          end else begin
            sr_q    <= (known_q && rsp_pos < rsp_size && rsp_pos < DEPTH_C) ? rsp_q : '0;
            rsp_pos <= rsp_pos + ONE_C;
            if (rsp_pos + ONE_C == rsp_len) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: interrupt pulses are single cycles
  a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  // R3: interrupt only accompanies an asserted acknowledge
  a_r3_irq_with_tack: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !tack_n);
  // R6: dispatch request held until the dispatcher finishes
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (disp_req && !disp_done) |=> disp_req);
  // R10: wrong-direction byte in idle leaves idle and raises nothing
  a_r10_idle_drop: assert property (@(posedge clk) disable iff (rst)
    (req_evt && state == ST_IDLE && !sr_dir_h2d) |=> (state == ST_IDLE && !irq_q));
  // R11: stored argument count never passes the buffer depth
  a_r11_arg_bound: assert property (@(posedge clk) disable iff (rst)
    arg_pos <= DEPTH_C);
  // R12: acknowledge frozen while a dispatch is pending
  a_r12_tack_frozen: assert property (@(posedge clk) disable iff (rst)
    (disp_req && $past(disp_req)) |-> $stable(tack_n));
endmodule

// File: tb/hs_cmd_seq_bench.sv
module hs_cmd_seq_bench;
  localparam int DEPTH = 32;
  localparam int AW    = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, treq_n, tack_n, sr_dir_h2d, sr_irq;
  logic [7:0] sr_in, sr_out, lk_cmd, lk_arg_len, lk_rsp_len;
  logic lk_arg_var, lk_rsp_var;
  logic disp_req, rsp_we, disp_done, disp_known;
  logic [7:0] disp_cmd, disp_arg_cnt, arg_rdata, rsp_wdata, disp_rsp_size;
  logic [AW-1:0] arg_raddr, rsp_waddr;

  hs_cmd_seq u_hs_cmd_seq (
    .clk(clk), .rst(rst), .treq_n(treq_n), .tack_n(tack_n),
    .sr_dir_h2d(sr_dir_h2d), .sr_in(sr_in), .sr_out(sr_out), .sr_irq(sr_irq),
    .lk_cmd(lk_cmd), .lk_arg_var(lk_arg_var), .lk_arg_len(lk_arg_len),
    .lk_rsp_var(lk_rsp_var), .lk_rsp_len(lk_rsp_len),
    .disp_req(disp_req), .disp_cmd(disp_cmd), .disp_arg_cnt(disp_arg_cnt),
    .arg_raddr(arg_raddr), .arg_rdata(arg_rdata),
    .rsp_we(rsp_we), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
    .disp_done(disp_done), .disp_known(disp_known), .disp_rsp_size(disp_rsp_size)
  );

  // Bench lookup: bit0 = variable args, bits3:1 = fixed arg length,
  // bit4 = variable reply, bits7:5 = fixed reply length.
  assign lk_arg_var = lk_cmd[0];
  assign lk_arg_len = {5'd0, lk_cmd[3:1]};
  assign lk_rsp_var = lk_cmd[4];
  assign lk_rsp_len = {5'd0, lk_cmd[7:5]};

  function automatic bit known_f(input logic [7:0] c);
    return c[3:0] != 4'hF;
  endfunction
  function automatic logic [7:0] arg_f(input logic [7:0] c, input int i);
    return c ^ 8'(i * 29 + 1);
  endfunction
  function automatic logic [7:0] data_f(input logic [7:0] c, input int i);
    return c + 8'(3 * i) + arg_f(c, i);
  endfunction

  int n_chk = 0, n_bad = 0;
  int irq_cnt = 0, req_rises = 0;
  logic req_d = 1'b0;
  logic [7:0] cur_cmd = '0;
  int cur_n = 0;

  always @(negedge clk) begin
    if (sr_irq) irq_cnt++;
    if (disp_req && !req_d) req_rises++;
    req_d = disp_req;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Dispatcher model
  initial begin
    disp_done = 0; disp_known = 0; disp_rsp_size = 0;
    rsp_we = 0; rsp_waddr = '0; rsp_wdata = '0; arg_raddr = '0;
    forever begin
      @(negedge clk);
      if (disp_req) begin
        chk("R6 dispatched command", int'(disp_cmd), int'(cur_cmd));
        chk("R6 argument count", int'(disp_arg_cnt), cur_n);
        for (int i = 0; i < cur_n; i++) begin
          arg_raddr = AW'(i);
          @(negedge clk);
          chk("R6 argument readback", int'(arg_rdata), int'(arg_f(cur_cmd, i)));
        end
        for (int i = 0; i < cur_n; i++) begin
          rsp_we = 1; rsp_waddr = AW'(i); rsp_wdata = data_f(cur_cmd, i);
          @(negedge clk);
        end
        rsp_we = 0;
        repeat (2) @(negedge clk);
        disp_known = known_f(cur_cmd);
        disp_rsp_size = 8'(cur_n);
        disp_done = 1;
        @(negedge clk);
        disp_done = 0;
      end
    end
  end

  task automatic xfer(input bit h2d, input logic [7:0] d, input int exp_irq,
                      input string tag, output logic [7:0] got);
    int c0, t;
    @(negedge clk);
    sr_dir_h2d = h2d; sr_in = d; c0 = irq_cnt; treq_n = 0;
    t = 0;
    do begin @(negedge clk); t++; end while (tack_n && t < 300);
    #2;
    chk({tag, " R2 ack low"}, int'(tack_n), 0);
    chk({tag, " R3 irq count"}, irq_cnt - c0, exp_irq);
    got = sr_out;
    @(negedge clk);
    treq_n = 1;
    @(negedge clk);
    #2;
    if (disp_req) chk({tag, " R12 ack held in dispatch"}, int'(tack_n), 0);
    t = 0;
    while (!tack_n && t < 300) begin @(negedge clk); t++; end
    #2;
    chk({tag, " R2 ack released"}, int'(tack_n), 1);
  endtask

  task automatic run_cmd(input logic [7:0] c, input bit bad_idle, input bit bad_rsp);
    logic [7:0] g;
    int n, sz, len;
    bit kn;
    n = c[0] ? ((int'(c) * 7 + 3) % 11) : int'(c[3:1]);
    kn = known_f(c);
    cur_cmd = c; cur_n = n;
    if (bad_idle) xfer(1'b0, 8'hAA, 0, "R10 idle drop", g);
    xfer(1'b1, c, 1, "R4 command", g);
    if (c[0]) xfer(1'b1, 8'(n), 1, "R5 length byte", g);
    for (int i = 0; i < n; i++) xfer(1'b1, arg_f(c, i), 1, "R6 argument", g);
    if (c[4]) begin
      if (bad_rsp) xfer(1'b1, 8'h55, 0, "R10 reply drop", g);
      xfer(1'b0, 8'h00, 1, "R7 size", g);
      sz = kn ? n : 0;
      chk("R7 size byte", int'(g), sz);
      for (int i = 0; i < sz; i++) begin
        xfer(1'b0, 8'h00, 1, "R7 data", g);
        chk("R7 reply byte", int'(g), int'(data_f(c, i)));
      end
    end else begin
      len = int'(c[7:5]);
      if (bad_rsp && len > 0) xfer(1'b1, 8'h55, 0, "R10 reply drop", g);
      for (int i = 0; i < len; i++) begin
        xfer(1'b0, 8'h00, 1, "R8 data", g);
        chk("R8 fixed reply byte", int'(g), (kn && i < n) ? int'(data_f(c, i)) : 0);
      end
    end
    // R9: back in idle, so a device-to-host byte is dropped without interrupt
    xfer(1'b0, 8'h00, 0, "R9 idle probe", g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] g;
    int r0;
    rst = 1; treq_n = 1; sr_dir_h2d = 1; sr_in = '0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ack idle", int'(tack_n), 1);
    chk("R1 no irq", int'(sr_irq), 0);
    chk("R1 no dispatch", int'(disp_req), 0);

    for (int c = 0; c < 256; c++)
      run_cmd(8'(c), (c % 16) == 5, (c % 8) == 3);

    // R11: declared count beyond the buffer never dispatches
    r0 = req_rises;
    cur_cmd = 8'h01; cur_n = 0;
    xfer(1'b1, 8'h01, 1, "R11 command", g);
    xfer(1'b1, 8'd34, 1, "R11 length", g);
    for (int i = 0; i < 34; i++) xfer(1'b1, 8'(i), 1, "R11 argument", g);
    chk("R11 no dispatch on overflow", req_rises - r0, 0);
    chk("R11 dispatch idle", int'(disp_req), 0);

    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R1 ack idle after reset", int'(tack_n), 1);
    chk("R1 no irq after reset", int'(sr_irq), 0);
    chk("R1 no dispatch after reset", int'(disp_req), 0);
    run_cmd(8'h23, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule